// File: doc/BRIEF.md
# Dual-Master Banked Memory Crossbar

This crossbar sits between a processor's fetch port and its load/store port on one side and three storage targets plus a peripheral bus on the other. The targets are a read-only boot image, and two RAM banks that together form one contiguous RAM region. Each target has its own arbiter. When the two ports address different targets, both are served in the same cycle. They are serialized only when they land on the same target.

Both ports use a level request that is held, together with its address, until the acknowledge appears. The load/store port also carries write data, a write enable and a per-byte write mask. Its accesses to the upper half of the address space pass straight through to a strobe/acknowledge peripheral bus. The storage targets are modelled inside the block as synchronous arrays with one cycle of read latency. The boot image is computed rather than loaded: word `k` holds `0xB0C7_0000 + k`. Each RAM bank decodes a 64KB window. Its physical depth is a parameter, and offsets beyond that depth wrap.

Top module: `mem_xbar`

## Requirements
- R1: Address decode is as follows:
  - 0x000000–0x0003FF selects the boot image.
  - 0x010000–0x01FFFF selects RAM bank 0.
  - 0x020000–0x02FFFF selects RAM bank 1.
  - Any address with bit 23 set selects the peripheral bus.
  - Every other address is unmapped.
- R2: A granted storage access is acknowledged exactly one cycle after it is granted. The acknowledge lasts one cycle, and read data is valid in that cycle. A port is not granted again in its own acknowledge cycle.
- R3: If both ports request different storage targets, both are acknowledged in the same cycle, one cycle after the request.
- R4: If both ports request the same storage target, only one is served. After reset the load/store port wins the first such collision on every target. The loser is acknowledged one cycle after the winner.
- R5: Each target keeps its own priority state, and it alternates on every collision at that target. The port that lost the previous collision at a target wins the next one there.
- R6: A load/store write to a RAM bank updates only the bytes whose mask bit is set. Mask bit k covers data bits 8k+7:8k.
- R7: The two banks are separate storage. A write at an offset in one bank leaves the same offset in the other bank unchanged.
- R8: Either port can read the boot image, and word k reads as 0xB0C70000+k. Writes to the boot image are acknowledged in the usual cycle and leave its contents unchanged.
- R9: A load/store access to the peripheral region raises the peripheral strobe in the same cycle as the request. The strobe carries the address, write enable, byte mask and write data. The port's acknowledge and read data follow the peripheral acknowledge and read data in the same cycle.
- R10: An unmapped access from either port, and a fetch-port access to the peripheral region, are acknowledged one cycle later with read data 0. Such an access raises no peripheral strobe.
- R11: While reset is asserted, and in the first cycle after it is released, both acknowledges and the peripheral strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Fetch-port request, held until acknowledged |
| i_addr | input | 24 | Fetch-port byte address |
| i_ack | output | 1 | Fetch-port acknowledge |
| i_rdata | output | 32 | Fetch-port read data, valid with i_ack |
| d_req | input | 1 | Load/store request, held until acknowledged |
| d_addr | input | 24 | Load/store byte address |
| d_we | input | 1 | Load/store write enable |
| d_mask | input | 4 | Load/store byte mask |
| d_wdata | input | 32 | Load/store write data |
| d_ack | output | 1 | Load/store acknowledge |
| d_rdata | output | 32 | Load/store read data, valid with d_ack |
| p_stb | output | 1 | Peripheral strobe |
| p_addr | output | 24 | Peripheral address |
| p_we | output | 1 | Peripheral write enable |
| p_sel | output | 4 | Peripheral byte select |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data |
| p_ack | input | 1 | Peripheral acknowledge |

## Verification
Directed pairs come first:
- A fetch and a store aimed at different targets check the parallel path.
- Two back-to-back collisions on the same bank show both the initial winner and the alternation.
- Masked stores over a known word expose any byte-lane mix-up.
- Writes to the boot image and accesses at the region edges separate correct decode from aliasing.

A seeded random mix of both ports over all five destinations then runs against a bench-side model. The model keeps per-target priority bits and bank shadows, and it applies writes in grant order. This catches wrong ordering between a colliding read and write, wrong bank selection, and a priority state shared between targets.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   typedef enum logic [2:0] {
      T_ROM    = 3'd0,
      T_BANK0  = 3'd1,
      T_BANK1  = 3'd2,
      T_NONE   = 3'd3,
      T_PERIPH = 3'd4
   } tgt_e;

   localparam int NUM_MEM = 3;

   // region boundaries (byte addresses, 24-bit space)
   localparam logic [23:0] ROM_LIMIT  = 24'h000400;
   localparam logic [7:0]  BANK0_PAGE = 8'h01;
   localparam logic [7:0]  BANK1_PAGE = 8'h02;

   function automatic tgt_e addr_decode(input logic [23:0] a);
      tgt_e t;
      if (a[23])                 t = T_PERIPH;
      else if (a < ROM_LIMIT)    t = T_ROM;
      else if (a[23:16] == BANK0_PAGE) t = T_BANK0;
      else if (a[23:16] == BANK1_PAGE) t = T_BANK1;
      else                       t = T_NONE;
      return t;
   endfunction

   function automatic logic [31:0] rom_word(input logic [15:0] idx);
      return {16'hB0C7, idx};
   endfunction

endpackage

// File: rtl/xbar_arb.sv
module xbar_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic req_d,
   output logic gnt_i,
   output logic gnt_d
);
   // favor_i set: fetch port wins the next collision
   logic favor_i;
   logic clash;

   assign clash = req_i & req_d;
   assign gnt_i = req_i & (~req_d | favor_i);
   assign gnt_d = req_d & (~req_i | ~favor_i);

   always_ff @(posedge clk) begin
      if (!rst_n)     favor_i <= 1'b0;
      else if (clash) favor_i <= ~favor_i;
   end
endmodule

// File: rtl/xbar_store.sv
module xbar_store #(
   parameter int WORDS     = 256,
   parameter bit READ_ONLY = 1'b0,
   parameter int DW        = 32,
   localparam int IW       = $clog2(WORDS),
   localparam int MW       = DW / 8
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [MW-1:0] mask,
   input  logic [IW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   if (READ_ONLY) begin : g_rom
      logic unused_wr;
      assign unused_wr = ^{we, mask, wdata};
      always_ff @(posedge clk) begin
         if (en) rdata <= DW'(xbar_pkg::rom_word(16'(addr)));
      end
   end else begin : g_ram
      logic [DW-1:0] mem [WORDS];
      always_ff @(posedge clk) begin
         if (en) begin
            rdata <= mem[addr];
            if (we) begin
               for (int b = 0; b < MW; b++) begin
                  if (mask[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
               end
            end
         end
      end
   end
endmodule

// File: rtl/mem_xbar.sv
module mem_xbar #(
   parameter int DW         = 32,
   parameter int AW         = 24,
   parameter int BANK_WORDS = 1024,
   parameter int ROM_WORDS  = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            i_req,
   input  logic [AW-1:0]   i_addr,
   output logic            i_ack,
   output logic [DW-1:0]   i_rdata,
   input  logic            d_req,
   input  logic [AW-1:0]   d_addr,
   input  logic            d_we,
   input  logic [DW/8-1:0] d_mask,
   input  logic [DW-1:0]   d_wdata,
   output logic            d_ack,
   output logic [DW-1:0]   d_rdata,
   output logic            p_stb,
   output logic [AW-1:0]   p_addr,
   output logic            p_we,
   output logic [DW/8-1:0] p_sel,
   output logic [DW-1:0]   p_wdata,
   input  logic [DW-1:0]   p_rdata,
   input  logic            p_ack
);
   import xbar_pkg::*;

   localparam int BANK_IW = $clog2(BANK_WORDS);
   localparam int ROM_IW  = $clog2(ROM_WORDS);

   if (DW != 32) begin : g_bad_dw
      $error("mem_xbar: DW must be 32");
   end
   if (AW != 24) begin : g_bad_aw
      $error("mem_xbar: AW must be 24");
   end
   if ((1 << BANK_IW) != BANK_WORDS || BANK_WORDS > 16384) begin : g_bad_bank
      $error("mem_xbar: BANK_WORDS must be a power of two up to 16384");
   end
   if (ROM_WORDS != 256) begin : g_bad_rom
      $error("mem_xbar: boot image is 1KB (256 words)");
   end

   tgt_e i_tgt, d_tgt, i_src_q, d_src_q;
   logic i_ack_q, d_ack_q;
   logic i_live, d_live, d_per;
   logic i_done, d_done;
   logic [NUM_MEM-1:0] req_i, req_d, gnt_i, gnt_d;
   logic [DW-1:0] tgt_rdata [NUM_MEM];
   logic unused_lsb;

   assign unused_lsb = ^i_addr[1:0];

   assign i_tgt  = addr_decode(i_addr);
   assign d_tgt  = addr_decode(d_addr);
   assign i_live = i_req & ~i_ack_q;
   assign d_live = d_req & ~d_ack_q;

   for (genvar t = 0; t < NUM_MEM; t++) begin : g_tgt
      logic [AW-1:0] sel_addr;

      assign req_i[t]  = i_live && (i_tgt == tgt_e'(t));
      assign req_d[t]  = d_live && (d_tgt == tgt_e'(t));
      assign sel_addr  = gnt_d[t] ? d_addr : i_addr;

      xbar_arb u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req_i (req_i[t]),
         .req_d (req_d[t]),
         .gnt_i (gnt_i[t]),
         .gnt_d (gnt_d[t])
      );

      if (t == 0) begin : g_rom
         xbar_store #(.WORDS(ROM_WORDS), .READ_ONLY(1'b1), .DW(DW)) u_mem (
            .clk   (clk),
            .en    (gnt_i[t] | gnt_d[t]),
            .we    (gnt_d[t] & d_we),
            .mask  (d_mask),
            .addr  (sel_addr[2 +: ROM_IW]),
            .wdata (d_wdata),
            .rdata (tgt_rdata[t])
         );
      end else begin : g_ram
         xbar_store #(.WORDS(BANK_WORDS), .READ_ONLY(1'b0), .DW(DW)) u_mem (
            .clk   (clk),
            .en    (gnt_i[t] | gnt_d[t]),
            .we    (gnt_d[t] & d_we),
            .mask  (d_mask),
            .addr  (sel_addr[2 +: BANK_IW]),
            .wdata (d_wdata),
            .rdata (tgt_rdata[t])
         );
      end
   end

   // completion: any grant, or an access with no storage behind it
   assign i_done = (|gnt_i) | (i_live && (i_tgt inside {T_NONE, T_PERIPH}));
   assign d_done = (|gnt_d) | (d_live && (d_tgt == T_NONE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         i_ack_q <= 1'b0;
         d_ack_q <= 1'b0;
         i_src_q <= T_NONE;
         d_src_q <= T_NONE;
      end else begin
         i_ack_q <= i_done;
         d_ack_q <= d_done;
         if (i_done) i_src_q <= i_tgt;
         if (d_done) d_src_q <= d_tgt;
      end
   end

   function automatic logic [DW-1:0] pick(input tgt_e s,
                                          input logic [DW-1:0] r0,
                                          input logic [DW-1:0] r1,
                                          input logic [DW-1:0] r2);
      logic [DW-1:0] v;
      case (s)
         T_ROM:   v = r0;
         T_BANK0: v = r1;
         T_BANK1: v = r2;
         default: v = '0;
      endcase
      return v;
   endfunction

   // peripheral pass-through, load/store port only
   assign d_per   = d_req && (d_tgt == T_PERIPH);
   assign p_stb   = d_per;
   assign p_addr  = d_addr;
   assign p_we    = d_we;
   assign p_sel   = d_mask;
   assign p_wdata = d_wdata;

   assign i_ack   = i_ack_q;
   assign i_rdata = i_ack_q ? pick(i_src_q, tgt_rdata[0], tgt_rdata[1], tgt_rdata[2]) : '0;
   assign d_ack   = d_ack_q | (d_per & p_ack);
   assign d_rdata = d_ack_q ? pick(d_src_q, tgt_rdata[0], tgt_rdata[1], tgt_rdata[2])
                  : (d_per ? p_rdata : '0);
endmodule

// File: rtl/xbar_props.sv
module xbar_props #(
   parameter int DW = 32,
   parameter int AW = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            i_req,
   input logic [AW-1:0]   i_addr,
   input logic            i_ack,
   input logic [DW-1:0]   i_rdata,
   input logic            d_req,
   input logic [AW-1:0]   d_addr,
   input logic            d_ack,
   input logic            p_stb,
   input logic [2:0]      gnt_i,
   input logic [2:0]      gnt_d
);
   import xbar_pkg::*;

   tgt_e it, dt;
   logic i_mem, d_mem;
   assign it    = addr_decode(i_addr);
   assign dt    = addr_decode(d_addr);
   assign i_mem = it inside {T_ROM, T_BANK0, T_BANK1};
   assign d_mem = dt inside {T_ROM, T_BANK0, T_BANK1};

   // R2: an acknowledge answers a request of the previous cycle
   p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      i_ack |-> $past(i_req));

   // R4: a target never serves both ports in one cycle
   p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_i & gnt_d) == 3'b000);

   // R3: different storage targets are served together
   p_parallel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_req && d_req && !i_ack && !d_ack && i_mem && d_mem && it != dt)
      |-> (i_ack && d_ack));

   // R4: a collision acknowledges exactly one port first
   p_collide_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_req && d_req && !i_ack && !d_ack && i_mem && it == dt)
      |-> (i_ack != d_ack));

   // R9: strobe only for a load/store request in the upper region
   p_stb_data_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      p_stb |-> (d_req && d_addr[AW-1]));

   // R10: fetch to the peripheral region completes with zero data
   p_fetch_periph_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_req && !i_ack && i_addr[AW-1]) |-> (i_ack && i_rdata == '0));
endmodule

bind mem_xbar xbar_props #(.DW(DW), .AW(AW)) u_props (
   .clk     (clk),
   .rst_n   (rst_n),
   .i_req   (i_req),
   .i_addr  (i_addr),
   .i_ack   (i_ack),
   .i_rdata (i_rdata),
   .d_req   (d_req),
   .d_addr  (d_addr),
   .d_ack   (d_ack),
   .p_stb   (p_stb),
   .gnt_i   (gnt_i),
   .gnt_d   (gnt_d)
);

// File: tb/sim_mem_xbar.sv
`timescale 1ns/1ps
module sim_mem_xbar;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_req = 1'b0;
   logic [23:0] i_addr = '0;
   logic        i_ack;
   logic [31:0] i_rdata;
   logic        d_req = 1'b0;
   logic [23:0] d_addr = '0;
   logic        d_we = 1'b0;
   logic [3:0]  d_mask = '0;
   logic [31:0] d_wdata = '0;
   logic        d_ack;
   logic [31:0] d_rdata;
   logic        p_stb;
   logic [23:0] p_addr;
   logic        p_we;
   logic [3:0]  p_sel;
   logic [31:0] p_wdata;
   logic [31:0] p_rdata;
   logic        p_ack;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mem_xbar u0 (.*);

   // peripheral responder: acknowledges one cycle after the strobe
   int          stb_count;
   logic [23:0] cap_addr;
   logic        cap_we;
   logic [3:0]  cap_sel;
   logic [31:0] cap_wdata;

   function automatic logic [31:0] pfn(input logic [23:0] a);
      return 32'hC300_0000 ^ {8'h00, a};
   endfunction

   assign p_rdata = pfn(p_addr);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_ack     <= 1'b0;
         stb_count <= 0;
      end else begin
         p_ack <= p_stb && !p_ack;
         if (p_stb) begin
            stb_count <= stb_count + 1;
            cap_addr  <= p_addr;
            cap_we    <= p_we;
            cap_sel   <= p_sel;
            cap_wdata <= p_wdata;
         end
      end
   end

   // reference model
   logic [31:0] mb [2][64];
   bit          vb [2][64];
   bit          pri [3];

   function automatic int bdec(input logic [23:0] a);
      if (a[23]) return 4;
      if (a < 24'h000400) return 0;
      if (a >= 24'h010000 && a < 24'h020000) return 1;
      if (a >= 24'h020000 && a < 24'h030000) return 2;
      return 3;
   endfunction

   task automatic model_read(input logic [23:0] a, output logic [31:0] v, output bit ok);
      int t = bdec(a);
      v = '0; ok = 1'b1;
      if (t == 0) v = 32'hB0C7_0000 + 32'(a[9:2]);
      else if (t == 1 || t == 2) begin
         v  = mb[t-1][a[7:2]];
         ok = vb[t-1][a[7:2]];
      end
   endtask

   task automatic model_write(input logic [23:0] a, input logic [31:0] w, input logic [3:0] m);
      int t = bdec(a);
      if (t == 1 || t == 2) begin
         if (!vb[t-1][a[7:2]]) begin
            if (m != 4'hF) return;
            vb[t-1][a[7:2]] = 1'b1;
         end
         for (int b = 0; b < 4; b++)
            if (m[b]) mb[t-1][a[7:2]][8*b +: 8] = w[8*b +: 8];
      end
   endtask

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic do_pair(input bit ien, input logic [23:0] ia,
                          input bit den, input logic [23:0] da, input bit dwe,
                          input logic [3:0] dm, input logic [31:0] dwd, input string rq);
      int it = bdec(ia);
      int dt = bdec(da);
      bit coll = ien && den && it == dt && it < 3;
      bit i_first = 1'b1;
      int icyc = 1, dcyc = 1, igot = 0, dgot = 0, stb0;
      logic [31:0] iexp = '0, dexp = '0;
      bit iok = 1'b0, dok = 1'b0;
      if (coll) begin
         i_first = pri[it];
         pri[it] = !pri[it];
         icyc = i_first ? 1 : 2;
         dcyc = i_first ? 2 : 1;
      end
      if (coll && !i_first) begin
         if (dwe) model_write(da, dwd, dm); else model_read(da, dexp, dok);
         if (ien) begin
            if (it >= 3) begin iexp = '0; iok = 1; end else model_read(ia, iexp, iok);
         end
      end else begin
         if (ien) begin
            if (it >= 3) begin iexp = '0; iok = 1; end else model_read(ia, iexp, iok);
         end
         if (den) begin
            if (dt == 4) begin dexp = pfn(da); dok = !dwe; end
            else if (dwe) model_write(da, dwd, dm);
            else model_read(da, dexp, dok);
         end
      end
      stb0 = stb_count;
      i_req = ien; i_addr = ia;
      d_req = den; d_addr = da; d_we = dwe; d_mask = dm; d_wdata = dwd;
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         if (i_ack) begin
            if (!ien || igot != 0) chk(rq, "spurious fetch ack", 32'd1, 32'd0);
            else begin
               igot = c;
               if (iok) chk(rq, "fetch rdata", i_rdata, iexp);
               i_req = 1'b0;
            end
         end
         if (d_ack) begin
            if (!den || dgot != 0) chk(rq, "spurious data ack", 32'd1, 32'd0);
            else begin
               dgot = c;
               if (dok) chk(rq, "data rdata", d_rdata, dexp);
               d_req = 1'b0;
            end
         end
      end
      if (ien) chk(rq, "fetch ack cycle", 32'(igot), 32'(icyc));
      if (den) chk(rq, "data ack cycle", 32'(dgot), 32'(dcyc));
      if (den && dt == 4) begin
         chk("R9", "strobe count", 32'(stb_count - stb0), 32'd1);
         chk("R9", "p_addr", {8'h0, cap_addr}, {8'h0, da});
         chk("R9", "p_we/p_sel", {27'h0, cap_we, cap_sel}, {27'h0, dwe, dm});
         if (dwe) chk("R9", "p_wdata", cap_wdata, dwd);
      end else begin
         chk("R10", "no strobe", 32'(stb_count - stb0), 32'd0);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 64; w++) begin mb[b][w] = '0; vb[b][w] = 1'b0; end
      for (int t = 0; t < 3; t++) pri[t] = 1'b0;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11", "acks/stb in reset", {29'h0, i_ack, d_ack, p_stb}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "acks/stb after reset", {29'h0, i_ack, d_ack, p_stb}, 32'h0);

      // R1, R8: boot image edges, read by each port
      do_pair(1, 24'h0003FC, 0, 24'h0, 0, 4'h0, 32'h0, "R8");
      do_pair(0, 24'h0, 1, 24'h000010, 0, 4'h0, 32'h0, "R8");
      // R1, R10: just past the boot image, gaps, top of lower half
      do_pair(1, 24'h000400, 1, 24'h030000, 0, 4'h0, 32'h0, "R10");
      do_pair(1, 24'h7FFFFC, 1, 24'h00FFFC, 0, 4'h0, 32'h0, "R1");
      // R8: write to the boot image is ignored
      do_pair(0, 24'h0, 1, 24'h000014, 1, 4'hF, 32'hDEAD_BEEF, "R8");
      do_pair(1, 24'h000014, 0, 24'h0, 0, 4'h0, 32'h0, "R8");
      // R7: same offset in both banks stays separate
      do_pair(0, 24'h0, 1, 24'h010020, 1, 4'hF, 32'h1111_0000, "R7");
      do_pair(0, 24'h0, 1, 24'h020020, 1, 4'hF, 32'h2222_0000, "R7");
      do_pair(1, 24'h010020, 1, 24'h020020, 0, 4'h0, 32'h0, "R7");
      // R6: masked store
      do_pair(0, 24'h0, 1, 24'h010040, 1, 4'hF, 32'h1122_3344, "R6");
      do_pair(0, 24'h0, 1, 24'h010040, 1, 4'b0101, 32'hAABB_CCDD, "R6");
      do_pair(1, 24'h010040, 0, 24'h0, 0, 4'h0, 32'h0, "R6");
      model_read(24'h010040, v, finished);
      finished = 0;
      chk("R6", "model masked value", v, 32'h11BB_33DD);
      // R3: different targets in parallel
      do_pair(1, 24'h010040, 1, 24'h020044, 1, 4'hF, 32'h5555_AAAA, "R3");
      // R4, R5: two collisions on bank 1, then the boot image
      do_pair(1, 24'h020044, 1, 24'h020044, 1, 4'hF, 32'h0BAD_F00D, "R4");
      do_pair(1, 24'h020048, 1, 24'h020044, 0, 4'h0, 32'h0, "R5");
      do_pair(1, 24'h000000, 1, 24'h000004, 0, 4'h0, 32'h0, "R5");
      // R9: peripheral read and write
      do_pair(0, 24'h0, 1, 24'h800010, 0, 4'h0, 32'h0, "R9");
      do_pair(1, 24'h010020, 1, 24'hA00004, 1, 4'b0011, 32'hCAFE_1234, "R9");
      // R10: fetch into the peripheral region
      do_pair(1, 24'h800000, 0, 24'h0, 0, 4'h0, 32'h0, "R10");

      // random mix: R2 timing, R3/R4/R5 arbitration, R6/R7 storage
      for (int n = 0; n < 600; n++) begin
         logic [23:0] ia, da;
         int ti = int'($urandom_range(0, 4));
         int td = int'($urandom_range(0, 4));
         logic [23:0] off_i = {16'h0, 2'b00, 6'($urandom_range(0, 63)), 2'b00};
         logic [23:0] off_d = {16'h0, 2'b00, 6'($urandom_range(0, 63)), 2'b00};
         ia = (ti == 0) ? off_i : (ti == 1) ? 24'h010000 | off_i :
              (ti == 2) ? 24'h020000 | off_i : (ti == 3) ? 24'h040000 | off_i : 24'h800000 | off_i;
         da = (td == 0) ? off_d : (td == 1) ? 24'h010000 | off_d :
              (td == 2) ? 24'h020000 | off_d : (td == 3) ? 24'h040000 | off_d : 24'h800000 | off_d;
         do_pair(1'($urandom_range(0, 3) != 0), ia, 1'($urandom_range(0, 3) != 0), da,
                 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom(), "R2");
      end

      @(negedge clk);
      finish_run();
   end
endmodule